// File: doc/BRIEF.md
# Multi-format stereo audio serial receiver

This block turns a three-wire serial audio stream into parallel stereo samples. The three wires are a bit clock, a word clock that marks the left and right halves of each frame, and a data line. The serial pins are oversampled by the block's own system clock. The block finds the rising edges of the bit clock and tracks the word-clock transitions to position every incoming bit inside its half-frame. It then shifts the bits that fall inside the selected word window into a capture register. When the right word of a frame is complete, the block presents both channels together for a single cycle.

Four framings are supported. They differ in which word-clock level marks the left channel, in how far the first bit is delayed, and in whether the word sits at the start or at the end of its half-frame. One of the framings is a packed frame of 32 bit clocks. The word length can be 16, 18, 20 or 24 bits. Format and word length come from a static configuration input, which upstream pin straps or a control register may drive. Each captured word is sign-extended before it is output.

The system clock must run at least four times faster than the bit clock. The configuration must stay constant while frames are being received.

Top module: `stereo_serial_rx`

## Requirements
- R1: Data is twos-complement and shifted most significant bit first. It is sampled on rising bit-clock edges, and in each frame the left word is received before the right word.
- R2: With fmt_sel = 2'b00 (I2S), word clock low marks the left half and high marks the right half. The first data bit is taken on the second rising bit-clock edge after a word-clock change.
- R3: With fmt_sel = 2'b01 (left-justified), word clock high marks left and low marks right. The first data bit is taken on the first rising bit-clock edge after a word-clock change.
- R4: With fmt_sel = 2'b10 (right-justified), word clock high marks left. Each half-frame is 32 bit clocks, and the word starts after 32 minus the word length bit clocks, so its last bit is the final bit before the next word-clock change.
- R5: With fmt_sel = 2'b11 (packed), each half-frame is 16 bit clocks, word clock high marks left, and the 16-bit word fills the half exactly. wlen_sel is ignored in this mode.
- R6: wlen_sel selects the word length: 2'b00 = 16, 2'b01 = 18, 2'b10 = 20, 2'b11 = 24 bits. Bits outside the word window have no effect on the output.
- R7: Every output sample is the received word sign-extended to the full output width.
- R8: smp_valid is high for exactly one system-clock cycle after the right word of a frame completes. In that cycle smp_left and smp_right hold the left and right words of that frame, and both keep their values until the next strobe.
- R9: No word is captured before the first word-clock transition after reset. A frame whose left word was not fully received after alignment produces no strobe.
- R10: After reset, smp_left and smp_right are zero and smp_valid is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_bclk | input | 1 | Serial bit clock |
| ser_wclk | input | 1 | Word clock selecting the left or right half |
| ser_data | input | 1 | Serial data line |
| fmt_sel | input | 2 | Framing select (see R2 to R5) |
| wlen_sel | input | 2 | Word length select (see R6) |
| smp_left | output | SAMPLE_W | Sign-extended left sample |
| smp_right | output | SAMPLE_W | Sign-extended right sample |
| smp_valid | output | 1 | One-cycle strobe marking a new sample pair |

## Verification
The bench fills every bit slot outside the word window with ones. A receiver whose window is one bit early or late, or that reads trailing slots in I2S or left-justified mode, therefore returns corrupted words instead of the expected values. It also drives negative and positive words at each length, so a design that sign-extends from the wrong bit outputs a wrong upper field. Packed mode is run with the 24-bit length selected, which catches a design that does not force 16 bits there. A stream that starts in the middle of a left half after reset checks that a design without alignment does not emit an extra, corrupted pair. Strobe counts per frame catch a strobe that lasts more than one cycle or that fires on the left word.

// File: rtl/stereo_rx_pkg.sv
package stereo_rx_pkg;

   localparam int MAX_WORD = 24;
   localparam int WLEN_W   = 5;

   typedef enum logic [1:0] {
      FMT_I2S    = 2'b00,
      FMT_LEFT   = 2'b01,
      FMT_RIGHT  = 2'b10,
      FMT_PACKED = 2'b11
   } rx_fmt_e;

   // word length select code -> number of bits
   function automatic logic [WLEN_W-1:0] word_bits(input logic [1:0] code);
      logic [WLEN_W-1:0] n;
      case (code)
         2'b00:   n = 5'd16;
         2'b01:   n = 5'd18;
         2'b10:   n = 5'd20;
         default: n = 5'd24;
      endcase
      return n;
   endfunction

   // replicate bit n-1 into every position at or above n
   function automatic logic [MAX_WORD-1:0] sign_fill(input logic [MAX_WORD-1:0] w,
                                                     input logic [WLEN_W-1:0] n);
      logic [MAX_WORD-1:0] r;
      logic                s;
      s = w[n - 5'd1];
      for (int i = 0; i < MAX_WORD; i++) begin
         r[i] = (i < int'(n)) ? w[i] : s;
      end
      return r;
   endfunction

endpackage

// File: rtl/stereo_rx_sync.sv
module stereo_rx_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bclk_in,
   input  logic wclk_in,
   input  logic data_in,
   output logic bclk_rise,
   output logic wclk_s,
   output logic data_s
);

   logic bclk_s;
   logic bclk_prev_q;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign bclk_s = bclk_in;
         assign wclk_s = wclk_in;
         assign data_s = data_in;
      end else begin : g_chain
         logic [SYNC_STAGES-1:0] b_q;
         logic [SYNC_STAGES-1:0] w_q;
         logic [SYNC_STAGES-1:0] d_q;
         if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  b_q <= '0;
                  w_q <= '0;
                  d_q <= '0;
               end else begin
                  b_q <= bclk_in;
                  w_q <= wclk_in;
                  d_q <= data_in;
               end
            end
         end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  b_q <= '0;
                  w_q <= '0;
                  d_q <= '0;
               end else begin
                  b_q <= {b_q[SYNC_STAGES-2:0], bclk_in};
                  w_q <= {w_q[SYNC_STAGES-2:0], wclk_in};
                  d_q <= {d_q[SYNC_STAGES-2:0], data_in};
               end
            end
         end
         assign bclk_s = b_q[SYNC_STAGES-1];
         assign wclk_s = w_q[SYNC_STAGES-1];
         assign data_s = d_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bclk_prev_q <= 1'b0;
      else        bclk_prev_q <= bclk_s;
   end

   assign bclk_rise = bclk_s & ~bclk_prev_q;

endmodule

// File: rtl/stereo_rx_framer.sv
module stereo_rx_framer
   import stereo_rx_pkg::*;
#(
   parameter int SLOT_BITS = 32,
   parameter int PACK_BITS = 16,
   parameter int CNT_W     = $clog2(SLOT_BITS) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bclk_rise,
   input  logic              wclk_s,
   input  logic              data_s,
   input  logic [1:0]        fmt,
   input  logic [1:0]        wlen,
   output logic              cap,
   output logic              cap_bit,
   output logic              is_left,
   output logic              word_done,
   output logic              left_start,
   output logic [WLEN_W-1:0] word_len,
   output logic              aligned_q
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic             wclk_prev_q;
   logic             wclk_known_q;
   logic [CNT_W-1:0] cnt_q;
   logic             edge_seen;
   logic [CNT_W-1:0] idx;
   logic             aligned_now;
   logic [CNT_W-1:0] first_idx;
   logic [CNT_W-1:0] last_idx;
   logic             in_window;
   rx_fmt_e          fmt_e;

   assign fmt_e = rx_fmt_e'(fmt);

   // position of the current bit inside its half-frame
   assign edge_seen   = bclk_rise && wclk_known_q && (wclk_s != wclk_prev_q);
   assign idx         = edge_seen ? '0 : ((cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1);
   assign aligned_now = aligned_q | edge_seen;

   assign word_len = (fmt_e == FMT_PACKED) ? WLEN_W'(PACK_BITS) : word_bits(wlen);
   assign is_left  = (fmt_e == FMT_I2S) ? ~wclk_s : wclk_s;

   always_comb begin
      case (fmt_e)
         FMT_I2S:   first_idx = CNT_W'(1);
         FMT_RIGHT: first_idx = CNT_W'(SLOT_BITS) - CNT_W'(word_len);
         default:   first_idx = '0;
      endcase
      last_idx = first_idx + CNT_W'(word_len) - 1'b1;
   end

   assign in_window  = (idx >= first_idx) && (idx <= last_idx);
   assign cap        = bclk_rise && aligned_now && in_window;
   assign cap_bit    = data_s;
   assign word_done  = cap && (idx == last_idx);
   assign left_start = edge_seen && is_left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wclk_prev_q  <= 1'b0;
         wclk_known_q <= 1'b0;
         cnt_q        <= CNT_MAX;
         aligned_q    <= 1'b0;
      end else if (bclk_rise) begin
         wclk_prev_q  <= wclk_s;
         wclk_known_q <= 1'b1;
         cnt_q        <= idx;
         aligned_q    <= aligned_now;
      end
   end

endmodule

// File: rtl/stereo_rx_assemble.sv
module stereo_rx_assemble
   import stereo_rx_pkg::*;
#(
   parameter int SAMPLE_W = 24
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cap,
   input  logic                cap_bit,
   input  logic                is_left,
   input  logic                word_done,
   input  logic                left_start,
   input  logic [WLEN_W-1:0]   word_len,
   output logic [SAMPLE_W-1:0] smp_left,
   output logic [SAMPLE_W-1:0] smp_right,
   output logic                smp_valid
);

   logic [MAX_WORD-1:0] shift_q;
   logic [MAX_WORD-1:0] next_word;
   logic [MAX_WORD-1:0] ext_word;
   logic [SAMPLE_W-1:0] ext_full;
   logic [SAMPLE_W-1:0] left_hold_q;
   logic                left_ok_q;

   assign next_word = {shift_q[MAX_WORD-2:0], cap_bit};
   assign ext_word  = sign_fill(next_word, word_len);

   generate
      if (SAMPLE_W > MAX_WORD) begin : g_widen
         assign ext_full = {{(SAMPLE_W-MAX_WORD){ext_word[MAX_WORD-1]}}, ext_word};
      end else begin : g_exact
         assign ext_full = ext_word;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shift_q     <= '0;
         left_hold_q <= '0;
         left_ok_q   <= 1'b0;
         smp_left    <= '0;
         smp_right   <= '0;
         smp_valid   <= 1'b0;
      end else begin
         smp_valid <= 1'b0;
         if (cap) shift_q <= next_word;
         if (word_done) begin
            if (is_left) begin
               left_hold_q <= ext_full;
               left_ok_q   <= 1'b1;
            end else if (left_ok_q) begin
               smp_left  <= left_hold_q;
               smp_right <= ext_full;
               smp_valid <= 1'b1;
               left_ok_q <= 1'b0;
            end
         end else if (left_start) begin
            left_ok_q <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/stereo_serial_rx.sv
module stereo_serial_rx
   import stereo_rx_pkg::*;
#(
   parameter int SAMPLE_W    = 24,
   parameter int SLOT_BITS   = 32,
   parameter int PACK_BITS   = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ser_bclk,
   input  logic                ser_wclk,
   input  logic                ser_data,
   input  logic [1:0]          fmt_sel,
   input  logic [1:0]          wlen_sel,
   output logic [SAMPLE_W-1:0] smp_left,
   output logic [SAMPLE_W-1:0] smp_right,
   output logic                smp_valid
);

   localparam int CNT_W = $clog2(SLOT_BITS) + 1;

   initial begin
      assert (SAMPLE_W >= MAX_WORD) else $fatal(1, "SAMPLE_W below longest word");
      assert (SLOT_BITS >= MAX_WORD) else $fatal(1, "SLOT_BITS shorter than longest word");
      assert (PACK_BITS >= 2 && PACK_BITS <= MAX_WORD) else $fatal(1, "PACK_BITS out of range");
      assert (SYNC_STAGES >= 0) else $fatal(1, "SYNC_STAGES negative");
   end

   logic              bclk_rise;
   logic              wclk_s;
   logic              data_s;
   logic              cap;
   logic              cap_bit;
   logic              is_left;
   logic              word_done;
   logic              left_start;
   logic [WLEN_W-1:0] word_len;
   logic              aligned_q;

   stereo_rx_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .bclk_in   (ser_bclk),
      .wclk_in   (ser_wclk),
      .data_in   (ser_data),
      .bclk_rise (bclk_rise),
      .wclk_s    (wclk_s),
      .data_s    (data_s)
   );

   stereo_rx_framer #(
      .SLOT_BITS (SLOT_BITS),
      .PACK_BITS (PACK_BITS),
      .CNT_W     (CNT_W)
   ) u_frm (
      .clk        (clk),
      .rst_n      (rst_n),
      .bclk_rise  (bclk_rise),
      .wclk_s     (wclk_s),
      .data_s     (data_s),
      .fmt        (fmt_sel),
      .wlen       (wlen_sel),
      .cap        (cap),
      .cap_bit    (cap_bit),
      .is_left    (is_left),
      .word_done  (word_done),
      .left_start (left_start),
      .word_len   (word_len),
      .aligned_q  (aligned_q)
   );

   stereo_rx_assemble #(.SAMPLE_W(SAMPLE_W)) u_asm (
      .clk        (clk),
      .rst_n      (rst_n),
      .cap        (cap),
      .cap_bit    (cap_bit),
      .is_left    (is_left),
      .word_done  (word_done),
      .left_start (left_start),
      .word_len   (word_len),
      .smp_left   (smp_left),
      .smp_right  (smp_right),
      .smp_valid  (smp_valid)
   );

endmodule

// File: rtl/stereo_serial_rx_chk.sv
module stereo_serial_rx_chk #(
   parameter int SAMPLE_W = 24
) (
   input logic                clk,
   input logic                rst_n,
   input logic [1:0]          fmt_sel,
   input logic [1:0]          wlen_sel,
   input logic [SAMPLE_W-1:0] smp_left,
   input logic [SAMPLE_W-1:0] smp_right,
   input logic                smp_valid,
   input logic                is_left,
   input logic                word_done,
   input logic                aligned_q
);

   // R8: the strobe never lasts two cycles
   p_strobe_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      smp_valid |=> !smp_valid);

   // R8: outputs only move together with the strobe
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_valid |-> ($stable(smp_left) && $stable(smp_right)));

   // R8: a strobe follows completion of a right word
   p_right_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      smp_valid |-> $past(word_done && !is_left));

   // R9: no word completes before the stream is aligned
   p_done_aligned_r9: assert property (@(posedge clk) disable iff (!rst_n)
      word_done |-> aligned_q);

   // R7: 16-bit words fill the upper field with the sign bit
   p_sext16_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && fmt_sel != 2'b11 && wlen_sel == 2'b00) |->
         (smp_left[SAMPLE_W-1:15] == {(SAMPLE_W-15){smp_left[15]}} &&
          smp_right[SAMPLE_W-1:15] == {(SAMPLE_W-15){smp_right[15]}}));

endmodule

bind stereo_serial_rx stereo_serial_rx_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .fmt_sel   (fmt_sel),
   .wlen_sel  (wlen_sel),
   .smp_left  (smp_left),
   .smp_right (smp_right),
   .smp_valid (smp_valid),
   .is_left   (is_left),
   .word_done (word_done),
   .aligned_q (aligned_q)
);

// File: tb/stereo_serial_rx_test.sv
`timescale 1ns/1ps
module stereo_serial_rx_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bclk = 1'b0;
   logic        wclk = 1'b0;
   logic        sdat = 1'b0;
   logic [1:0]  fmt = 2'b00;
   logic [1:0]  wl = 2'b00;
   logic [23:0] smp_l;
   logic [23:0] smp_r;
   logic        smp_v;

   int          n_chk = 0;
   int          n_bad = 0;
   int          n_got = 0;
   logic [23:0] got_l [0:7];
   logic [23:0] got_r [0:7];
   bit          done = 0;

   always #4 clk = ~clk;

   stereo_serial_rx uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .ser_bclk  (bclk),
      .ser_wclk  (wclk),
      .ser_data  (sdat),
      .fmt_sel   (fmt),
      .wlen_sel  (wl),
      .smp_left  (smp_l),
      .smp_right (smp_r),
      .smp_valid (smp_v)
   );

   // record every strobe away from the active edge
   always @(negedge clk) begin
      if (smp_v) begin
         if (n_got < 8) begin
            got_l[n_got] = smp_l;
            got_r[n_got] = smp_r;
         end
         n_got = n_got + 1;
      end
   end

   task automatic check(input bit ok, input string req, input logic [23:0] act,
                        input logic [23:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [23:0] sx(input logic [23:0] v, input int w);
      logic [23:0] mask;
      logic [23:0] m;
      mask = 24'((64'd1 << w) - 1);
      m = v & mask;
      if (m[w-1]) m = m | ~mask;
      return m;
   endfunction

   task automatic send_bit(input logic lr, input logic b);
      @(negedge clk);
      bclk = 1'b0;
      wclk = lr;
      sdat = b;
      @(negedge clk);
      @(negedge clk);
      bclk = 1'b1;
      @(negedge clk);
   endtask

   // one half-frame; slots outside the word carry ones
   task automatic send_half(input int f, input int w, input int half,
                            input logic [23:0] word, input logic lr);
      int first;
      first = (f == 0) ? 1 : ((f == 2) ? half - w : 0);
      for (int i = 0; i < half; i++) begin
         if (i >= first && i < first + w) send_bit(lr, word[w-1-(i-first)]);
         else                             send_bit(lr, 1'b1);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      bclk = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // R10: reset values
   task automatic t_reset_state();
      do_reset();
      check(smp_l == 24'h0, "R10 reset left", smp_l, 24'h0);
      check(smp_r == 24'h0, "R10 reset right", smp_r, 24'h0);
      check(smp_v == 1'b0, "R10 reset strobe", {23'h0, smp_v}, 24'h0);
   endtask

   // two frames in one framing and length, then compare the captured pairs
   task automatic run_case(input int f, input int wsel, input logic [23:0] l0,
                           input logic [23:0] r0, input logic [23:0] l1,
                           input logic [23:0] r1, input string tag);
      int   w;
      int   half;
      logic lvl;
      w    = (f == 3) ? 16 : ((wsel == 0) ? 16 : (wsel == 1) ? 18 : (wsel == 2) ? 20 : 24);
      half = (f == 3) ? 16 : 32;
      lvl  = (f == 0) ? 1'b0 : 1'b1;
      @(negedge clk);
      fmt = 2'(f);
      wl  = 2'(wsel);
      n_got = 0;
      repeat (4) send_bit(~lvl, 1'b1);
      send_half(f, w, half, l0, lvl);
      send_half(f, w, half, r0, ~lvl);
      send_half(f, w, half, l1, lvl);
      send_half(f, w, half, r1, ~lvl);
      repeat (12) @(negedge clk);
      check(n_got == 2, {tag, " R8 strobe count"}, 24'(n_got), 24'd2);
      check(got_l[0] == sx(l0, w), {tag, " R1 R7 left 0"}, got_l[0], sx(l0, w));
      check(got_r[0] == sx(r0, w), {tag, " R1 R7 right 0"}, got_r[0], sx(r0, w));
      check(got_l[1] == sx(l1, w), {tag, " R6 left 1"}, got_l[1], sx(l1, w));
      check(got_r[1] == sx(r1, w), {tag, " R6 right 1"}, got_r[1], sx(r1, w));
      check(smp_l == sx(l1, w) && smp_r == sx(r1, w), {tag, " R8 hold"}, smp_r, sx(r1, w));
   endtask

   task automatic t_i2s();
      run_case(0, 3, 24'h5A3C96, 24'h812345, 24'hFFFFFE, 24'h000001, "R2 I2S 24");
      run_case(0, 0, 24'h00F00F, 24'h008001, 24'h007FFF, 24'h00ABCD, "R2 I2S 16");
   endtask

   task automatic t_left();
      run_case(1, 1, 24'h02A5A5, 24'h01FFFF, 24'h030001, 24'h00C3C3, "R3 LJ 18");
      run_case(1, 2, 24'h0F0F0F, 24'h080000, 24'h07FFFF, 24'h0A0A0A, "R3 LJ 20");
   endtask

   task automatic t_right();
      run_case(2, 0, 24'h00CAFE, 24'h001234, 24'h008000, 24'h007FFE, "R4 RJ 16");
      run_case(2, 2, 24'h0ABCDE, 24'h012345, 24'h0FFFFF, 24'h000000, "R4 RJ 20");
      run_case(2, 3, 24'hC00003, 24'h3FFFFC, 24'h800000, 24'h7FFFFF, "R4 RJ 24");
      run_case(2, 1, 24'h020000, 24'h01FFFF, 24'h03FFFF, 24'h000055, "R4 RJ 18");
   endtask

   // R5: packed frame, 24-bit length selected but ignored
   task automatic t_packed();
      run_case(3, 3, 24'h00BEEF, 24'h004321, 24'h00FFFF, 24'h000080, "R5 packed");
   endtask

   // R9: stream starts inside a left half right after reset
   task automatic t_misalign();
      do_reset();
      @(negedge clk);
      fmt = 2'b01;
      wl  = 2'b00;
      n_got = 0;
      for (int i = 0; i < 10; i++) send_bit(1'b1, i[0]);
      send_half(1, 16, 32, 24'h001111, 1'b0);
      send_half(1, 16, 32, 24'h00A001, 1'b1);
      send_half(1, 16, 32, 24'h000777, 1'b0);
      send_half(1, 16, 32, 24'h00F00F, 1'b1);
      send_half(1, 16, 32, 24'h004444, 1'b0);
      repeat (12) @(negedge clk);
      check(n_got == 2, "R9 strobes after late start", 24'(n_got), 24'd2);
      check(got_l[0] == 24'hFFA001, "R9 first aligned left", got_l[0], 24'hFFA001);
      check(got_r[0] == 24'h000777, "R9 first aligned right", got_r[0], 24'h000777);
      check(got_l[1] == 24'hFFF00F, "R9 second left", got_l[1], 24'hFFF00F);
      check(got_r[1] == 24'h004444, "R9 second right", got_r[1], 24'h004444);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL R8 watchdog: got running expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      t_reset_state();
      t_i2s();
      t_left();
      t_right();
      t_packed();
      t_misalign();
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule